// File: doc/BRIEF.md
# Stage-2 TLB Invalidate-by-Address Engine

This block is a small, fully associative cache of stage-2 (guest-intermediate to physical) translations. Its main job is to invalidate entries by intermediate address. An invalidate request carries a 128-bit operand, the current VMID, a flag saying whether the requester runs in the Non-secure state, and a variant flag. The block decodes the operand. It clears every valid entry that matches the VMID, the targeted address space and the page address. The address compare is masked to the block size held in each entry. When the operand carries a usable level hint, an entry is cleared only if its granule and level equal the hint.

After the entries are cleared, the block tracks completion. Each outstanding memory access is announced with an issue strobe and closed with a retire strobe. Each strobe carries the index of the entry that translated the access and the access's XS attribute. The invalidation is reported complete with a one-cycle done pulse. In the full variant this happens once every tagged access on the cleared entries has retired. In the XS-filtered variant it happens once those accesses with XS equal to 0 have retired. Entries are loaded through a write port. A registered lookup port lets the surrounding logic, and the bench, see which translations are present.

Top module: `s2_tlb_inval`

## Requirements
- R1: After reset no entry is valid, so every lookup misses, `inv_ready` is 1 and `inv_done` is 0.
- R2: Lookup answers arrive one cycle after `lk_valid`. An entry hits when its VMID and space bit match and the page number matches above the entry's block size. For granule code 01 (4KB), 10 (16KB) or 11 (64KB) at level L, the low 9·(3−L), 2+11·(3−L) or 4+13·(3−L) page-number bits are ignored. The lowest hitting index is reported, together with its XS bit.
- R3: An accepted invalidate with no usable hint clears every valid entry with equal VMID, equal target space and an address inside that entry's block. Other entries are kept.
- R4: Operand bit 63 picks the target space (0 Secure, 1 Non-secure). When `inv_req_nonsec` is 1, bit 63 is ignored and the Non-secure space is targeted.
- R5: The hint sits in operand bits [47:44]. Bits [47:46] give the granule (00 means no hint) and bits [45:44] give the level. With a usable hint, an entry whose granule or level differs is kept.
- R6: Hint codes 10_00 and 11_00 are reserved. Code 10_01 is also unusable when `lpa_en` is 0. All of these act as no hint. When `lpa_en` is 1, code 10_01 means 16KB level 1.
- R7: Code 01_00 means 4KB level 0 only when `lpa_en` is 1. Otherwise it acts as no hint.
- R8: When no tagged access is outstanding on the cleared entries, `inv_done` is high for exactly one cycle. This is the second cycle after the acceptance edge.
- R9: With `inv_xs_only` 0, done waits until every access on a cleared entry has retired, with both XS values counted. With `inv_xs_only` 1, done waits only for those accesses with XS 0. In both cases done rises in the second cycle after the retire that satisfies the condition.
- R10: `inv_ready` is 0 from the acceptance edge until `inv_done` is raised. A request presented while `inv_ready` is 0 has no effect.
- R11: When a fill and an invalidate that matches the old contents hit the same index in the same cycle, the entry ends invalid.
- R12: Accesses outstanding on entries that were not cleared do not delay `inv_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lpa_en | input | 1 | Large-address support enable for hint decoding |
| fill_valid | input | 1 | Write an entry this cycle |
| fill_idx | input | 3 | Entry index to write |
| fill_vmid | input | 16 | VMID of the written entry |
| fill_space | input | 1 | Space bit (1 Non-secure) |
| fill_pn | input | 44 | Intermediate address bits [55:12] |
| fill_gran | input | 2 | Granule code (01 4KB, 10 16KB, 11 64KB) |
| fill_lvl | input | 2 | Leaf level 0..3 |
| fill_xs | input | 1 | XS bit stored with the entry |
| lk_valid | input | 1 | Lookup request |
| lk_vmid | input | 16 | Lookup VMID |
| lk_space | input | 1 | Lookup space bit |
| lk_pn | input | 44 | Lookup address bits [55:12] |
| lk_hit | output | 1 | Registered lookup hit |
| lk_idx | output | 3 | Index of the lowest hitting entry |
| lk_xs | output | 1 | XS bit of that entry |
| iss_valid | input | 1 | Access issued |
| iss_idx | input | 3 | Entry used by the issued access |
| iss_xs | input | 1 | XS attribute of the issued access |
| ret_valid | input | 1 | Access retired |
| ret_idx | input | 3 | Entry used by the retired access |
| ret_xs | input | 1 | XS attribute of the retired access |
| inv_valid | input | 1 | Invalidate request |
| inv_ready | output | 1 | Request accepted when high together with inv_valid |
| inv_op | input | 128 | Operand: [107:64] address, [63] space, [47:44] hint |
| inv_xs_only | input | 1 | 1 selects the XS-filtered completion |
| inv_vmid | input | 16 | Current VMID for the invalidate |
| inv_req_nonsec | input | 1 | Requester is in the Non-secure state |
| inv_done | output | 1 | One-cycle completion pulse |

## Verification
The assertions rely on a few properties of the environment. A retire is never sent for an entry and XS class whose outstanding count is zero. No count is pushed past its capacity. While an invalidate is waiting, no new access is issued against an entry it cleared, because that entry is invalid and offers no translation. The stimulus keeps to these limits in several ways. It issues at most two accesses per entry. It retires only accesses it has issued, matching each in index and XS value. It issues only before an invalidate starts or on entries that stay valid.

// File: rtl/s2inv_pkg.sv
package s2inv_pkg;
  parameter int VMID_W = 16;
  parameter int PN_W   = 44;

  typedef struct packed {
    logic              valid;
    logic [VMID_W-1:0] vmid;
    logic              space;
    logic [PN_W-1:0]   pn;
    logic [1:0]        gran;
    logic [1:0]        lvl;
    logic              xs;
  } ent_t;

  // Page-number bits that take part in the compare for a block of the given
  // granule and level (bit 0 of the page number is address bit 12).
  function automatic logic [PN_W-1:0] keep_mask(input logic [1:0] gran,
                                                input logic [1:0] lvl);
    int up;
    int drop;
    up = 3 - int'(lvl);
    case (gran)
      2'b10:   drop = 2 + 11 * up;
      2'b11:   drop = 4 + 13 * up;
      default: drop = 9 * up;
    endcase
    return {PN_W{1'b1}} << drop;
  endfunction
endpackage

// File: rtl/s2inv_hint_dec.sv
module s2inv_hint_dec (
  input  logic [3:0] ttl,
  input  logic       lpa_en,
  output logic       hint_on,
  output logic [1:0] hint_gran,
  output logic [1:0] hint_lvl
);
  always_comb begin
    hint_on = 1'b1;
    case (ttl[3:2])
      2'b00: hint_on = 1'b0;
      2'b01: if (ttl[1:0] == 2'd0 && !lpa_en) hint_on = 1'b0;
      2'b10: if (ttl[1:0] == 2'd0 || (ttl[1:0] == 2'd1 && !lpa_en)) hint_on = 1'b0;
      default: if (ttl[1:0] == 2'd0) hint_on = 1'b0;
    endcase
    hint_gran = hint_on ? ttl[3:2] : 2'b00;
    hint_lvl  = hint_on ? ttl[1:0] : 2'b00;
  end
endmodule

// File: rtl/s2inv_entry.sv
module s2inv_entry
  import s2inv_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              fill_we,
  input  ent_t              fill_ent,
  input  logic              inv_fire,
  input  logic [VMID_W-1:0] inv_vmid,
  input  logic              inv_space,
  input  logic [PN_W-1:0]   inv_pn,
  input  logic              hint_on,
  input  logic [1:0]        hint_gran,
  input  logic [1:0]        hint_lvl,
  input  logic [VMID_W-1:0] lk_vmid,
  input  logic              lk_space,
  input  logic [PN_W-1:0]   lk_pn,
  output logic              inv_hit,
  output logic              lk_hit,
  output logic              ent_xs
);
  ent_t            ent_q;
  logic [PN_W-1:0] keep;
  logic            hint_ok;

  assign keep    = keep_mask(ent_q.gran, ent_q.lvl);
  assign hint_ok = !hint_on || (ent_q.gran == hint_gran && ent_q.lvl == hint_lvl);
  assign inv_hit = ent_q.valid && ent_q.vmid == inv_vmid && ent_q.space == inv_space &&
                   ((ent_q.pn ^ inv_pn) & keep) == '0 && hint_ok;
  assign lk_hit  = ent_q.valid && ent_q.vmid == lk_vmid && ent_q.space == lk_space &&
                   ((ent_q.pn ^ lk_pn) & keep) == '0;
  assign ent_xs  = ent_q.xs;

  // Invalidate beats a same-cycle fill (R11).
  always_ff @(posedge clk) begin
    if (rst)                      ent_q <= '0;
    else if (inv_fire && inv_hit) ent_q.valid <= 1'b0;
    else if (fill_we)             ent_q <= fill_ent;
  end

  assert_cleared_no_hit_R3: assert property (@(posedge clk) disable iff (rst)
    (inv_fire && inv_hit && !fill_we) |=> !lk_hit);
  assert_fill_loses_R11: assert property (@(posedge clk) disable iff (rst)
    (inv_fire && inv_hit && fill_we) |=> !inv_hit);
endmodule

// File: rtl/s2inv_drain.sv
module s2inv_drain #(
  parameter int NUM_ENT = 8,
  parameter int CNT_W   = 4,
  localparam int IDX_W  = $clog2(NUM_ENT)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               iss_valid,
  input  logic [IDX_W-1:0]   iss_idx,
  input  logic               iss_xs,
  input  logic               ret_valid,
  input  logic [IDX_W-1:0]   ret_idx,
  input  logic               ret_xs,
  input  logic               start,
  input  logic [NUM_ENT-1:0] start_mask,
  input  logic               start_xs_only,
  output logic               busy,
  output logic               done
);
  logic [NUM_ENT-1:0] pend_q;
  logic [NUM_ENT-1:0] clear_v;
  logic               xs_only_q;
  logic               busy_q;
  logic               done_q;

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_cnt
    logic [CNT_W-1:0] c0_q, c1_q;
    logic inc0, inc1, dec0, dec1;
    assign inc0 = iss_valid && iss_idx == IDX_W'(i) && !iss_xs;
    assign inc1 = iss_valid && iss_idx == IDX_W'(i) &&  iss_xs;
    assign dec0 = ret_valid && ret_idx == IDX_W'(i) && !ret_xs;
    assign dec1 = ret_valid && ret_idx == IDX_W'(i) &&  ret_xs;

    always_ff @(posedge clk) begin
      if (rst) begin
        c0_q <= '0;
        c1_q <= '0;
      end else begin
        if (inc0 && !dec0)      c0_q <= c0_q + 1'b1;
        else if (dec0 && !inc0) c0_q <= c0_q - 1'b1;
        if (inc1 && !dec1)      c1_q <= c1_q + 1'b1;
        else if (dec1 && !inc1) c1_q <= c1_q - 1'b1;
      end
    end

    assign clear_v[i] = !pend_q[i] || (c0_q == '0 && (xs_only_q || c1_q == '0));

    assert_no_underflow_R9: assert property (@(posedge clk) disable iff (rst)
      ((dec0 && !inc0) |-> c0_q != '0) and ((dec1 && !inc1) |-> c1_q != '0));
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
      ((inc0 && !dec0) |-> c0_q != '1) and ((inc1 && !dec1) |-> c1_q != '1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      pend_q    <= '0;
      xs_only_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        busy_q    <= 1'b1;
        pend_q    <= start_mask;
        xs_only_q <= start_xs_only;
      end else if (busy_q && &clear_v) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        pend_q <= '0;
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;

  assert_done_one_cycle_R8: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  assert_done_after_wait_R9: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy_q && $past(busy_q));
endmodule

// File: rtl/s2_tlb_inval.sv
module s2_tlb_inval
  import s2inv_pkg::*;
#(
  parameter int NUM_ENT = 8,
  parameter int CNT_W   = 4,
  localparam int IDX_W  = $clog2(NUM_ENT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lpa_en,
  input  logic              fill_valid,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [VMID_W-1:0] fill_vmid,
  input  logic              fill_space,
  input  logic [PN_W-1:0]   fill_pn,
  input  logic [1:0]        fill_gran,
  input  logic [1:0]        fill_lvl,
  input  logic              fill_xs,
  input  logic              lk_valid,
  input  logic [VMID_W-1:0] lk_vmid,
  input  logic              lk_space,
  input  logic [PN_W-1:0]   lk_pn,
  output logic              lk_hit,
  output logic [IDX_W-1:0]  lk_idx,
  output logic              lk_xs,
  input  logic              iss_valid,
  input  logic [IDX_W-1:0]  iss_idx,
  input  logic              iss_xs,
  input  logic              ret_valid,
  input  logic [IDX_W-1:0]  ret_idx,
  input  logic              ret_xs,
  input  logic              inv_valid,
  output logic              inv_ready,
  input  logic [127:0]      inv_op,
  input  logic              inv_xs_only,
  input  logic [VMID_W-1:0] inv_vmid,
  input  logic              inv_req_nonsec,
  output logic              inv_done
);
  logic               hint_on;
  logic [1:0]         hint_gran, hint_lvl;
  logic               tgt_space;
  logic [PN_W-1:0]    op_pn;
  logic               inv_fire;
  logic               busy;
  ent_t               fill_ent;
  logic [NUM_ENT-1:0] inv_hit_v, lk_hit_v, xs_v;
  logic               lk_any, lk_sel_xs;
  logic [IDX_W-1:0]   lk_sel;
  logic               lk_hit_q, lk_xs_q;
  logic [IDX_W-1:0]   lk_idx_q;
  logic               rsvd_unused;

  assign rsvd_unused = ^{inv_op[127:108], inv_op[62:48], inv_op[43:0]};
  assign op_pn     = inv_op[107:64];
  assign tgt_space = inv_req_nonsec ? 1'b1 : inv_op[63];
  assign inv_ready = !busy;
  assign inv_fire  = inv_valid && inv_ready;

  s2inv_hint_dec u_hint (
    .ttl(inv_op[47:44]), .lpa_en(lpa_en),
    .hint_on(hint_on), .hint_gran(hint_gran), .hint_lvl(hint_lvl)
  );

  always_comb begin
    fill_ent       = '0;
    fill_ent.valid = 1'b1;
    fill_ent.vmid  = fill_vmid;
    fill_ent.space = fill_space;
    fill_ent.pn    = fill_pn;
    fill_ent.gran  = fill_gran;
    fill_ent.lvl   = fill_lvl;
    fill_ent.xs    = fill_xs;
  end

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
    s2inv_entry u_ent (
      .clk(clk), .rst(rst),
      .fill_we(fill_valid && fill_idx == IDX_W'(i)), .fill_ent(fill_ent),
      .inv_fire(inv_fire), .inv_vmid(inv_vmid), .inv_space(tgt_space), .inv_pn(op_pn),
      .hint_on(hint_on), .hint_gran(hint_gran), .hint_lvl(hint_lvl),
      .lk_vmid(lk_vmid), .lk_space(lk_space), .lk_pn(lk_pn),
      .inv_hit(inv_hit_v[i]), .lk_hit(lk_hit_v[i]), .ent_xs(xs_v[i])
    );
  end

  always_comb begin
    lk_any    = 1'b0;
    lk_sel    = '0;
    lk_sel_xs = 1'b0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (lk_hit_v[i]) begin
        lk_any    = 1'b1;
        lk_sel    = IDX_W'(i);
        lk_sel_xs = xs_v[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_hit_q <= 1'b0;
      lk_idx_q <= '0;
      lk_xs_q  <= 1'b0;
    end else begin
      lk_hit_q <= lk_valid && lk_any;
      lk_idx_q <= lk_sel;
      lk_xs_q  <= lk_sel_xs;
    end
  end

  assign lk_hit = lk_hit_q;
  assign lk_idx = lk_idx_q;
  assign lk_xs  = lk_xs_q;

  s2inv_drain #(.NUM_ENT(NUM_ENT), .CNT_W(CNT_W)) u_drain (
    .clk(clk), .rst(rst),
    .iss_valid(iss_valid), .iss_idx(iss_idx), .iss_xs(iss_xs),
    .ret_valid(ret_valid), .ret_idx(ret_idx), .ret_xs(ret_xs),
    .start(inv_fire), .start_mask(inv_hit_v), .start_xs_only(inv_xs_only),
    .busy(busy), .done(inv_done)
  );

  assert_ready_drops_R10: assert property (@(posedge clk) disable iff (rst)
    inv_fire |=> !inv_ready);
  assert_level0_gated_R7: assert property (@(posedge clk) disable iff (rst)
    (hint_on && hint_lvl == 2'd0) |-> (lpa_en && hint_gran == 2'b01));
  assert_hit_needs_query_R2: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> $past(lk_valid));
endmodule

// File: tb/s2_tlb_inval_tb.sv
module s2_tlb_inval_tb;
  import s2inv_pkg::*;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic lpa_en = '0, fill_valid = '0, fill_space = '0, fill_xs = '0;
  logic [IW-1:0] fill_idx = '0, iss_idx = '0, ret_idx = '0;
  logic [VMID_W-1:0] fill_vmid = '0, lk_vmid = '0, inv_vmid = '0;
  logic [PN_W-1:0] fill_pn = '0, lk_pn = '0;
  logic [1:0] fill_gran = '0, fill_lvl = '0;
  logic lk_valid = '0, lk_space = '0, iss_valid = '0, iss_xs = '0, ret_valid = '0, ret_xs = '0;
  logic inv_valid = '0, inv_xs_only = '0, inv_req_nonsec = '0;
  logic [127:0] inv_op = '0;
  logic lk_hit, lk_xs, inv_ready, inv_done;
  logic [IW-1:0] lk_idx;

  s2_tlb_inval u_dut (
    .clk(clk), .rst(rst), .lpa_en(lpa_en),
    .fill_valid(fill_valid), .fill_idx(fill_idx), .fill_vmid(fill_vmid), .fill_space(fill_space),
    .fill_pn(fill_pn), .fill_gran(fill_gran), .fill_lvl(fill_lvl), .fill_xs(fill_xs),
    .lk_valid(lk_valid), .lk_vmid(lk_vmid), .lk_space(lk_space), .lk_pn(lk_pn),
    .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_xs(lk_xs),
    .iss_valid(iss_valid), .iss_idx(iss_idx), .iss_xs(iss_xs),
    .ret_valid(ret_valid), .ret_idx(ret_idx), .ret_xs(ret_xs),
    .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_op(inv_op), .inv_xs_only(inv_xs_only),
    .inv_vmid(inv_vmid), .inv_req_nonsec(inv_req_nonsec), .inv_done(inv_done)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [IW+1:0] exp_q[$];
  string tag_q[$];
  logic lk_fire = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: one expected item per lookup, compared when the answer appears.
  always @(posedge clk) lk_fire <= lk_valid;
  always @(negedge clk) begin
    if (lk_fire && exp_q.size() > 0) begin
      logic [IW+1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(lk_hit == e[IW+1], {t, " hit"}, lk_hit, e[IW+1]);
      if (e[IW+1]) begin
        chk(lk_idx == e[IW-1:0], {t, " idx"}, lk_idx, e[IW-1:0]);
        chk(lk_xs == e[IW], {t, " xs"}, lk_xs, e[IW]);
      end
    end
  end

  function automatic logic [127:0] mkop(input logic [43:0] pn, input bit ns, input logic [3:0] ttl);
    logic [127:0] o;
    o = '0;
    o[107:64] = pn;
    o[63] = ns;
    o[47:44] = ttl;
    return o;
  endfunction

  task automatic set_fill(input int idx, input int vm, input bit sp, input logic [43:0] pn,
                          input logic [1:0] g, input logic [1:0] l, input bit x);
    fill_valid = 1'b1; fill_idx = IW'(idx); fill_vmid = VMID_W'(vm); fill_space = sp;
    fill_pn = pn; fill_gran = g; fill_lvl = l; fill_xs = x;
  endtask

  task automatic fill(input int idx, input int vm, input bit sp, input logic [43:0] pn,
                      input logic [1:0] g, input logic [1:0] l, input bit x);
    set_fill(idx, vm, sp, pn, g, l, x);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic look(input int vm, input bit sp, input logic [43:0] pn,
                      input bit hit, input int idx, input bit x, input string tag);
    exp_q.push_back({hit, x, IW'(idx)});
    tag_q.push_back(tag);
    lk_valid = 1'b1; lk_vmid = VMID_W'(vm); lk_space = sp; lk_pn = pn;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic start_inv(input logic [127:0] op, input bit xo, input int vm, input bit nsreq);
    inv_valid = 1'b1; inv_op = op; inv_xs_only = xo; inv_vmid = VMID_W'(vm); inv_req_nonsec = nsreq;
  endtask

  task automatic end_inv();
    @(negedge clk);
    inv_valid = 1'b0;
    fill_valid = 1'b0;
  endtask

  task automatic wait_done(input int exp, input string tag);
    int lat;
    lat = 1;
    while (!inv_done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == exp, {tag, " done latency"}, lat, exp);
    @(negedge clk);
    chk(!inv_done && inv_ready, {tag, " single pulse, ready back"}, inv_done, 0);
  endtask

  task automatic inv(input logic [127:0] op, input bit xo, input int vm, input bit nsreq, input string tag);
    start_inv(op, xo, vm, nsreq);
    end_inv();
    wait_done(2, tag);
  endtask

  task automatic strobe(input bit is_ret, input int idx, input bit x);
    if (is_ret) begin ret_valid = 1'b1; ret_idx = IW'(idx); ret_xs = x; end
    else begin iss_valid = 1'b1; iss_idx = IW'(idx); iss_xs = x; end
    @(negedge clk);
    ret_valid = 1'b0;
    iss_valid = 1'b0;
  endtask

  task automatic quiet(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(!inv_done && !inv_ready, {tag, " still waiting"}, inv_done, 0);
    end
  endtask

  bit ended = 1'b0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1
    chk(inv_ready == 1'b1, "R1 ready after reset", inv_ready, 1);
    chk(inv_done == 1'b0, "R1 done after reset", inv_done, 0);
    look(5, 1, 44'h1000, 0, 0, 0, "R1 empty lookup");

    fill(0, 5, 1, 44'h1000, 2'b01, 2'd3, 0);
    fill(1, 5, 1, 44'h400, 2'b01, 2'd2, 1);
    fill(2, 5, 0, 44'h1000, 2'b01, 2'd3, 0);
    fill(3, 9, 1, 44'h1000, 2'b01, 2'd3, 1);
    fill(4, 5, 1, 44'h8000, 2'b10, 2'd3, 0);
    fill(5, 5, 1, 44'h20000, 2'b11, 2'd2, 1);
    fill(6, 5, 1, 44'h8000000, 2'b01, 2'd0, 0);
    // R2 block masking
    look(5, 1, 44'h1000, 1, 0, 0, "R2 4K L3 exact");
    look(5, 1, 44'h1001, 0, 0, 0, "R2 4K L3 next page");
    look(5, 1, 44'h5ff, 1, 1, 1, "R2 4K L2 top");
    look(5, 1, 44'h600, 0, 0, 0, "R2 4K L2 past block");
    look(5, 0, 44'h1000, 1, 2, 0, "R2 secure twin");
    look(9, 1, 44'h1000, 1, 3, 1, "R2 other vmid");
    look(5, 1, 44'h8003, 1, 4, 0, "R2 16K L3");
    look(5, 1, 44'h3ffff, 1, 5, 1, "R2 64K L2");

    // R3 / R8
    inv(mkop(44'h1000, 1, 4'b0000), 0, 5, 0, "R3 R8 plain");
    look(5, 1, 44'h1000, 0, 0, 0, "R3 target cleared");
    look(5, 0, 44'h1000, 1, 2, 0, "R3 other space kept");
    look(9, 1, 44'h1000, 1, 3, 1, "R3 other vmid kept");

    // R4
    fill(0, 5, 1, 44'h1000, 2'b01, 2'd3, 0);
    inv(mkop(44'h1000, 0, 4'b0000), 0, 5, 1, "R4 nonsec forced");
    look(5, 1, 44'h1000, 0, 0, 0, "R4 NS entry cleared");
    look(5, 0, 44'h1000, 1, 2, 0, "R4 secure entry kept");
    inv(mkop(44'h1000, 0, 4'b0000), 0, 5, 0, "R4 secure select");
    look(5, 0, 44'h1000, 0, 0, 0, "R4 secure entry cleared");

    // R5
    inv(mkop(44'h4ab, 1, 4'b0111), 0, 5, 0, "R5 level mismatch");
    look(5, 1, 44'h400, 1, 1, 1, "R5 entry kept");
    inv(mkop(44'h4ab, 1, 4'b0110), 0, 5, 0, "R5 level match");
    look(5, 1, 44'h400, 0, 0, 0, "R5 entry cleared");

    // R6
    lpa_en = 1'b1;
    inv(mkop(44'h8001, 1, 4'b1001), 0, 5, 0, "R6 16K L1 with lpa");
    look(5, 1, 44'h8000, 1, 4, 0, "R6 16K L3 kept");
    lpa_en = 1'b0;
    inv(mkop(44'h8001, 1, 4'b1001), 0, 5, 0, "R6 16K 01 no lpa");
    look(5, 1, 44'h8000, 0, 0, 0, "R6 cleared as no hint");
    fill(4, 5, 1, 44'h8000, 2'b10, 2'd3, 0);
    inv(mkop(44'h8002, 1, 4'b1000), 0, 5, 0, "R6 16K reserved");
    look(5, 1, 44'h8000, 0, 0, 0, "R6 16K reserved cleared");
    inv(mkop(44'h2abcd, 1, 4'b1100), 0, 5, 0, "R6 64K reserved");
    look(5, 1, 44'h20000, 0, 0, 0, "R6 64K reserved cleared");

    // R7
    fill(0, 5, 1, 44'h1000, 2'b01, 2'd3, 0);
    lpa_en = 1'b1;
    inv(mkop(44'h1000, 1, 4'b0100), 0, 5, 0, "R7 L0 hint vs L3");
    look(5, 1, 44'h1000, 1, 0, 0, "R7 L3 entry kept");
    inv(mkop(44'h8000123, 1, 4'b0100), 0, 5, 0, "R7 L0 hint match");
    look(5, 1, 44'h8000000, 0, 0, 0, "R7 L0 entry cleared");
    lpa_en = 1'b0;
    inv(mkop(44'h1000, 1, 4'b0100), 0, 5, 0, "R7 no lpa");
    look(5, 1, 44'h1000, 0, 0, 0, "R7 treated as no hint");

    // R9 full, R10, R12
    fill(0, 5, 1, 44'h1000, 2'b01, 2'd3, 0);
    strobe(0, 0, 0);
    strobe(0, 0, 1);
    strobe(0, 3, 0);
    start_inv(mkop(44'h1000, 1, 4'b0000), 0, 5, 0);
    end_inv();
    quiet(4, "R9 full");
    start_inv(mkop(44'h1000, 1, 4'b0000), 0, 9, 0);
    end_inv();
    quiet(2, "R10 busy request");
    strobe(1, 0, 0);
    quiet(3, "R9 full xs1 pending");
    strobe(1, 0, 1);
    wait_done(2, "R9 R12 full drained");
    look(9, 1, 44'h1000, 1, 3, 1, "R10 busy request ignored");

    // R9 XS-filtered
    fill(0, 5, 1, 44'h1000, 2'b01, 2'd3, 0);
    strobe(0, 0, 1);
    strobe(0, 0, 0);
    start_inv(mkop(44'h1000, 1, 4'b0000), 1, 5, 0);
    end_inv();
    quiet(3, "R9 xs-only");
    strobe(1, 0, 0);
    wait_done(2, "R9 xs-only drained");
    strobe(1, 0, 1);
    strobe(1, 3, 0);

    // R11
    fill(1, 5, 1, 44'h400, 2'b01, 2'd2, 1);
    start_inv(mkop(44'h400, 1, 4'b0000), 0, 5, 0);
    set_fill(1, 5, 1, 44'h600, 2'b01, 2'd3, 0);
    end_inv();
    wait_done(2, "R11 collide");
    look(5, 1, 44'h600, 0, 0, 0, "R11 new fill dropped");
    look(5, 1, 44'h400, 0, 0, 0, "R11 old entry gone");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
    ended = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule